// File: doc/BRIEF.md
# Mode-Dependent GPIO Port Controller

This block is an eight-pin general-purpose I/O port. It holds a direction register and a data register, both reached through a single-cycle register bus in a 20-bit address space. Writes land on the clock edge. Reads are combinational on the address. Each direction bit sets the output enable of its pin. The value driven on an output pin comes from one of two sources: the data register, or an external pattern source that is selected pin by pin. When the data register is read, output pins return the latched bit and input pins return the level sampled on the pin.

A 2-bit operating-mode input changes how the port behaves after reset. In the upper mode group the top pin is held as an output and carries an address bit from the bus instead of port data. Software standby freezes the register contents, so pins that are outputs keep driving. Hardware standby reloads the direction register with its reset value.

Top module: `gpio_port_ctrl`

## Requirements
- R1: When direction bit i is 1, pinOe[i] is 1 and pin i is an output. When the bit is 0, pinOe[i] is 0 and pin i is an input.
- R2: A read at the direction address (20'hEE009) returns 8'hFF, whatever the register holds.
- R3: Synchronous active-high reset loads the direction register with 8'h00 when mode is 0 or 1, and with 8'h80 when mode is 2 or 3. Reset clears the data register to 8'h00 in every mode.
- R4: When mode is 2 or 3, pinOe[7] stays 1 even after a write of 0 to direction bit 7, and pinOut[7] follows the addrBit input.
- R5: The data register at 20'hFFFD9 can be written and read. A read returns the latched bit for each pin whose direction bit is 1, and pinIn for each pin whose direction bit is 0.
- R6: For each pin not taken by R4, pinOut[i] is patVal[i] when patEn[i] is 1 and the data bit when patEn[i] is 0. pinOe[i] still follows the direction bit alone.
- R7: While swStandby is 1 and hwStandby is 0, bus writes are ignored and both registers keep their values, so output pins keep driving.
- R8: When hwStandby is 1, the direction register loads its mode-dependent reset value on the next edge, even while swStandby is also 1. The data register is kept.
- R9: A write to any address other than the two register addresses has no effect. A read of any other address returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hwStandby | input | 1 | Hardware standby request, active high |
| swStandby | input | 1 | Software standby request, active high |
| mode | input | 2 | Operating mode; values 2 and 3 lock the top pin |
| busAddr | input | 20 | Register address |
| busWe | input | 1 | Write strobe for one cycle |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data |
| pinIn | input | 8 | Sampled pin levels |
| patEn | input | 8 | Per-pin pattern-source select |
| patVal | input | 8 | Pattern output values |
| addrBit | input | 1 | Address bit driven on the top pin in modes 2 and 3 |
| pinOe | output | 8 | Per-pin output enable |
| pinOut | output | 8 | Per-pin output value |

## Verification
The bench builds the block with its default parameters: eight pins, a 20-bit address, and the two register addresses above. Because the port is only eight bits wide, hand-picked patterns cover every pin's input path, output path and pattern-source path. With the top bit as the locked pin, both mode groups can be run from reset, and the lock on bit 7 can be checked against a write of zero. The same directed sequence also places standby requests against register writes, so both the priority of hardware standby and the write blocking in software standby are checked.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef struct packed {
    logic dirLoad;   // load mode-dependent reset value into direction
    logic dirWrite;  // bus write to direction register
    logic dataWrite; // bus write to data register
    logic dataClear; // clear data register
    logic lockTop;   // top pin locked as address output
  } portCtl_t;
endpackage

// File: rtl/gpio_port_control.sv
module gpio_port_control
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 20'hEE009,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 20'hFFFD9
) (
  input  logic              rst,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output portCtl_t          ctl,
  output logic              selDir,
  output logic              selData
);
  logic busActive;

  always_comb begin
    selDir    = (busAddr == DIR_ADDR);
    selData   = (busAddr == DATA_ADDR);
    busActive = busWe && !rst && !hwStandby && !swStandby;
    ctl.lockTop   = mode[1];
    ctl.dirLoad   = rst || hwStandby;
    ctl.dataClear = rst;
    ctl.dirWrite  = busActive && selDir;
    ctl.dataWrite = busActive && selData;
  end
endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  portCtl_t         ctl,
  input  logic             selDir,
  input  logic             selData,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] patEn,
  input  logic [WIDTH-1:0] patVal,
  input  logic             addrBit,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] pinOut
);
  localparam int TOP = WIDTH - 1;
  localparam logic [WIDTH-1:0] TOP_MASK = WIDTH'(1) << TOP;

  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] dataReg;
  logic [WIDTH-1:0] lockMask;
  logic [WIDTH-1:0] dirEff;
  logic [WIDTH-1:0] dataView;

  assign lockMask = ctl.lockTop ? TOP_MASK : '0;
  assign dirEff   = dirReg | lockMask;

  always_ff @(posedge clk) begin
    if (ctl.dirLoad)       dirReg <= lockMask;
    else if (ctl.dirWrite) dirReg <= busWdata | lockMask;
    if (ctl.dataClear)      dataReg <= '0;
    else if (ctl.dataWrite) dataReg <= busWdata;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic portVal;
    assign portVal     = patEn[i] ? patVal[i] : dataReg[i];
    assign dataView[i] = dirEff[i] ? dataReg[i] : pinIn[i];
    if (i == TOP) begin : g_top
      assign pinOut[i] = ctl.lockTop ? addrBit : portVal;
    end else begin : g_low
      assign pinOut[i] = portVal;
    end
  end

  assign pinOe = dirEff;

  always_comb begin
    if (selDir)       busRdata = '1;
    else if (selData) busRdata = dataView;
    else              busRdata = '0;
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 20'hEE009,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 20'hFFFD9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic [WIDTH-1:0]  pinIn,
  input  logic [WIDTH-1:0]  patEn,
  input  logic [WIDTH-1:0]  patVal,
  input  logic              addrBit,
  output logic [WIDTH-1:0]  pinOe,
  output logic [WIDTH-1:0]  pinOut
);
  portCtl_t ctl;
  logic selDir, selData;

  gpio_port_control #(.ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .DATA_ADDR(DATA_ADDR)) u_ctl (
    .rst(rst), .hwStandby(hwStandby), .swStandby(swStandby), .mode(mode),
    .busAddr(busAddr), .busWe(busWe), .ctl(ctl), .selDir(selDir), .selData(selData)
  );

  gpio_port_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .ctl(ctl), .selDir(selDir), .selData(selData),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .patEn(patEn), .patVal(patVal), .addrBit(addrBit),
    .pinOe(pinOe), .pinOut(pinOut)
  );
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 20'hEE009
) (
  input logic              clk,
  input logic              rst,
  input logic              hwStandby,
  input logic              swStandby,
  input logic [1:0]        mode,
  input logic [ADDR_W-1:0] busAddr,
  input logic [WIDTH-1:0]  busRdata,
  input logic [WIDTH-1:0]  patEn,
  input logic [WIDTH-1:0]  patVal,
  input logic              addrBit,
  input logic [WIDTH-1:0]  pinOe,
  input logic [WIDTH-1:0]  pinOut
);
  localparam int TOP = WIDTH - 1;

  a_r2_dir_reads_ones: assert property (@(posedge clk) disable iff (rst)
    (busAddr == DIR_ADDR) |-> (busRdata == '1));

  a_r3_reset_dir_low: assert property (@(posedge clk)
    rst |=> (pinOe[TOP-1:0] == '0));

  a_r4_top_locked: assert property (@(posedge clk) disable iff (rst)
    mode[1] |-> (pinOe[TOP] && (pinOut[TOP] == addrBit)));

  a_r6_pattern_select: assert property (@(posedge clk) disable iff (rst)
    ((patEn[TOP-1:0] & (pinOut[TOP-1:0] ^ patVal[TOP-1:0])) == '0));

  a_r7_sw_hold: assert property (@(posedge clk) disable iff (rst)
    (swStandby && !hwStandby) |=> $stable(pinOe[TOP-1:0]));

  a_r8_hw_clears: assert property (@(posedge clk) disable iff (rst)
    hwStandby |=> (pinOe[TOP-1:0] == '0));
endmodule

bind gpio_port_ctrl gpio_port_checker #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR)) u_chk (
  .clk(clk), .rst(rst), .hwStandby(hwStandby), .swStandby(swStandby), .mode(mode),
  .busAddr(busAddr), .busRdata(busRdata), .patEn(patEn), .patVal(patVal),
  .addrBit(addrBit), .pinOe(pinOe), .pinOut(pinOut)
);

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;
  localparam logic [19:0] DIRA = 20'hEE009;
  localparam logic [19:0] DATA = 20'hFFFD9;

  logic clk = 0, rst = 1, hwStandby = 0, swStandby = 0, busWe = 0, addrBit = 0;
  logic [1:0] mode = 0;
  logic [19:0] busAddr = 0;
  logic [7:0] busWdata = 0, pinIn = 0, patEn = 0, patVal = 0;
  logic [7:0] busRdata, pinOe, pinOut;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  gpio_port_ctrl u0 (.clk(clk), .rst(rst), .hwStandby(hwStandby), .swStandby(swStandby),
    .mode(mode), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .patEn(patEn), .patVal(patVal), .addrBit(addrBit),
    .pinOe(pinOe), .pinOut(pinOut));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset(logic [1:0] m);
    @(negedge clk); mode = m; rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic busWrite(logic [19:0] a, logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1;
    @(negedge clk); busWe = 0;
  endtask

  task automatic busRead(logic [19:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; #1 d = busRdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    pinIn = 8'h00;
    doReset(2'd1);
    check("R3 dir mode1", pinOe, 8'h00);
    busRead(DATA, d); check("R3 data mode1", d, 8'h00);
    doReset(2'd3);
    check("R3 dir mode3", pinOe, 8'h80);
    busRead(DATA, d); check("R3 data mode3", d, 8'h00);
  endtask

  task automatic t_direction();
    logic [7:0] d;
    doReset(2'd0);
    busWrite(DIRA, 8'hA5);
    check("R1 oe", pinOe, 8'hA5);
    busRead(DIRA, d); check("R2 dir read", d, 8'hFF);
  endtask

  task automatic t_data();
    logic [7:0] d;
    busWrite(DATA, 8'h3C);
    pinIn = 8'hF0;
    busRead(DATA, d); check("R5 mixed read", d, 8'h74);
    check("R5 pinOut", pinOut, 8'h3C);
  endtask

  task automatic t_pattern();
    patEn = 8'h0F; patVal = 8'h0A; #1;
    check("R6 pinOut", pinOut, 8'h3A);
    check("R6 oe", pinOe, 8'hA5);
    patEn = 0; patVal = 0;
  endtask

  task automatic t_lock();
    doReset(2'd2);
    busWrite(DIRA, 8'h00);
    check("R4 oe", pinOe, 8'h80);
    addrBit = 1; #1 check("R4 addr1", {7'd0, pinOut[7]}, 8'h01);
    addrBit = 0; #1 check("R4 addr0", {7'd0, pinOut[7]}, 8'h00);
  endtask

  task automatic t_sw();
    logic [7:0] d;
    doReset(2'd0);
    pinIn = 8'h00;
    busWrite(DIRA, 8'h5A);
    swStandby = 1;
    busWrite(DIRA, 8'h00);
    busWrite(DATA, 8'hFF);
    check("R7 oe held", pinOe, 8'h5A);
    check("R7 data held", pinOut, 8'h00);
    @(negedge clk); swStandby = 0;
    busRead(DATA, d); check("R7 read", d, 8'h00);
  endtask

  task automatic t_hw();
    busWrite(DATA, 8'h0F);
    @(negedge clk); swStandby = 1; hwStandby = 1;
    @(negedge clk); hwStandby = 0; swStandby = 0;
    check("R8 oe cleared", pinOe, 8'h00);
    check("R8 data kept", pinOut, 8'h0F);
    mode = 2'd3;
    busWrite(DIRA, 8'h7F);
    @(negedge clk); hwStandby = 1;
    @(negedge clk); hwStandby = 0;
    check("R8 oe mode3", pinOe, 8'h80);
  endtask

  task automatic t_miss();
    logic [7:0] d;
    doReset(2'd0);
    busWrite(DIRA, 8'h11);
    busWrite(20'hEE00A, 8'hFF);
    busWrite(20'hFFFD8, 8'hFF);
    check("R9 oe kept", pinOe, 8'h11);
    check("R9 data kept", pinOut, 8'h00);
    busRead(20'h12345, d); check("R9 read zero", d, 8'h00);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_direction(); t_data(); t_pattern();
        t_lock(); t_sw(); t_hw(); t_miss();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule